// File: doc/BRIEF.md
# Prioritised Claim/Complete Interrupt Controller

This block collects level-sensitive interrupt lines from a set of devices and hands them to a small number of interrupt targets, called contexts, through a 32-bit memory-mapped register bus. Each source has a programmable priority. Each context has its own enable mask and priority threshold, and its own request output. The request output is asserted when that context has a pending, enabled source whose priority is above its threshold.

A context takes ownership of a source by reading its claim register. The read returns the winning source ID and clears that source's pending flag in the same cycle. When the handler is done, software writes the ID back to the same register to complete it. A claimed source cannot raise a new request until it is completed. The completion is checked only against the enable mask of the writing context, not against the ID that context last claimed.

The bus has one access per cycle. Writes take effect at the clock edge. Read data appears on `rdata_o` one cycle after `re_i` and holds its value until the next read.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, all priorities, enables and thresholds are 0, no source is pending, every `irq_o` bit is 0 and `rdata_o` is 0.
- R2: The priority of source N (1..NUM_SRC) is at byte address 4*N. It stores PRIO_W bits and reads back zero-extended. Address 0 reads as 0 and ignores writes.
- R3: The pending word is at 0x1000, with source N at bit N. A high device line makes its source pending, visible on a read issued one cycle later. Writes to 0x1000 have no effect.
- R4: Context C's enable word is at 0x2000 + 0x80*C, with the same bit packing as the pending word. Bit 0, and bits above NUM_SRC, always read 0.
- R5: A read of context C's claim register at 0x200004 + 0x1000*C returns the ID of the pending, enabled source with nonzero priority that has the highest priority, or 0 if there is none. On equal priority the lowest ID wins. The returned source stops being pending at the same clock edge.
- R6: The threshold of context C is at 0x200000 + 0x1000*C and stores PRIO_W bits. `irq_o[C]` is 1 exactly when the best candidate under R5 has a priority strictly above that threshold. The threshold never changes what a claim returns.
- R7: After a source is claimed, it does not become pending again, even with its line held high, until a completion for it is accepted.
- R8: A write of ID to context C's claim register completes that ID if the ID is 1..NUM_SRC and enabled for C, whether or not C claimed it. Otherwise the write is ignored.
- R9: Reads of unimplemented or misaligned addresses return 0. Writes to them change no readable state.
- R10: A source claimed by one context is not returned by a later claim from any context until it has been completed and is pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address; bits 1:0 must be 0 for a hit |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe; a claim read has side effects |
| rdata_o | output | 32 | Read data, valid the cycle after `re_i` |
| src_i | input | NUM_SRC | Device lines; bit N-1 is source N |
| irq_o | output | NUM_CTX | Per-context interrupt request |

## Verification
A pending flag that fails to clear on a claim shows up at the next claim read of that context, as a repeated ID. A gateway that forgets its in-service state shows up one cycle after the claim, as the source reappearing in the pending word while its line stays high. An error in the priority or tie-break chain shows up directly in the claim value. An error in the threshold compare shows up on `irq_o` in the cycle after the threshold or pending state changes. The bench therefore compares `irq_o` on every cycle and every read result against a behavioural model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } sel_e;

  localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o
);

  logic svc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      svc_q  <= 1'b0;
    end else if (claim_i) begin
      pend_o <= 1'b0;
      svc_q  <= 1'b1;
    end else begin
      if (complete_i) svc_q <= 1'b0;
      // new request only while not in service
      if (!svc_q && line_i) pend_o <= 1'b1;
    end
  end

  // R5
  gw_claim_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |=> (!pend_o && svc_q));

  // R7
  gw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_q |=> !pend_o);

  // R7
  gw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_o && svc_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int SRC_W   = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC:1]               pend_i,
  input  logic [NUM_SRC:1]               en_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [SRC_W-1:0]               best_id_o,
  output logic                           irq_o
);

  logic [PRIO_W-1:0] best_prio;

  // ascending scan, strict compare: lowest ID keeps a tie
  always_comb begin
    best_id_o = '0;
    best_prio = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > best_prio)) begin
        best_id_o = SRC_W'(i);
        best_prio = prio_i[i];
      end
    end
  end

  assign irq_o = best_prio > thr_i;

  // R6
  arb_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (best_id_o != '0));

  // R5
  arb_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_id_o != '0) |-> (pend_i[best_id_o] && en_i[best_id_o] && (prio_i[best_id_o] != '0)));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [31:0]        wdata_i,
  input  logic               re_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_CTX-1:0] irq_o
);

  localparam int NW    = (NUM_SRC + 32) / 32;
  localparam int VEC_W = NW * 32;
  localparam int SRC_W = $clog2(NUM_SRC + 1);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int WRD_W = (NW > 1) ? $clog2(NW) : 1;

  logic [31:0] addr, en_off, ctx_off;
  sel_e        sel;
  logic [SRC_W-1:0] src_sel;
  logic [CTX_W-1:0] ctx_sel;
  logic [WRD_W-1:0] wrd_sel;

  logic [NUM_SRC:1][PRIO_W-1:0]     prio_q;
  logic [NUM_CTX-1:0][VEC_W-1:0]    en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]   thr_q;
  logic [NUM_SRC:1]                 pend;
  logic [VEC_W-1:0]                 pend_vec, en_mask;
  logic [NUM_CTX-1:0][SRC_W-1:0]    best_id;
  logic [SRC_W-1:0]                 claim_id, cmp_id;
  logic                             claim_hit, cmp_ok;
  logic [31:0]                      rd_data;

  assign addr    = 32'(addr_i);
  assign en_off  = addr - EN_BASE;
  assign ctx_off = addr - CTX_BASE;

  // address decode
  always_comb begin
    sel     = SEL_NONE;
    src_sel = '0;
    ctx_sel = '0;
    wrd_sel = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < PEND_BASE) begin
        if (addr[11:2] != '0 && 32'(addr[11:2]) <= NUM_SRC) begin
          sel     = SEL_PRIO;
          src_sel = SRC_W'(addr[11:2]);
        end
      end else if (addr < PEND_BASE + EN_STRIDE) begin
        if (32'(addr[6:2]) < NW) begin
          sel     = SEL_PEND;
          wrd_sel = WRD_W'(addr[6:2]);
        end
      end else if (addr >= EN_BASE && en_off < EN_STRIDE * NUM_CTX) begin
        if (32'(addr[6:2]) < NW) begin
          sel     = SEL_EN;
          ctx_sel = CTX_W'(en_off >> 7);
          wrd_sel = WRD_W'(addr[6:2]);
        end
      end else if (addr >= CTX_BASE && ctx_off < CTX_STRIDE * NUM_CTX) begin
        ctx_sel = CTX_W'(ctx_off >> 12);
        if (addr[11:0] == 12'h000)      sel = SEL_THR;
        else if (addr[11:0] == 12'h004) sel = SEL_CLAIM;
      end
    end
  end

  // ID 0 and IDs above NUM_SRC never exist
  always_comb begin
    pend_vec            = '0;
    pend_vec[NUM_SRC:1] = pend;
    en_mask             = '0;
    en_mask[NUM_SRC:1]  = '1;
  end

  assign claim_id  = best_id[ctx_sel];
  assign claim_hit = re_i && (sel == SEL_CLAIM);
  assign cmp_id    = wdata_i[SRC_W-1:0];
  assign cmp_ok    = we_i && (sel == SEL_CLAIM) && (wdata_i != '0)
                     && (wdata_i <= NUM_SRC) && en_q[ctx_sel][cmp_id];

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
    irq_gateway u_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_i     (src_i[g-1]),
      .claim_i    (claim_hit && (claim_id == SRC_W'(g))),
      .complete_i (cmp_ok && (cmp_id == SRC_W'(g))),
      .pend_o     (pend[g])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    irq_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .SRC_W   (SRC_W)
    ) u_arb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pend_i    (pend),
      .en_i      (en_q[c][NUM_SRC:1]),
      .prio_i    (prio_q),
      .thr_i     (thr_q[c]),
      .best_id_o (best_id[c]),
      .irq_o     (irq_o[c])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_PRIO:  rd_data = 32'(prio_q[src_sel]);
      SEL_PEND:  rd_data = pend_vec[{wrd_sel, 5'b0} +: 32];
      SEL_EN:    rd_data = en_q[ctx_sel][{wrd_sel, 5'b0} +: 32];
      SEL_THR:   rd_data = 32'(thr_q[ctx_sel]);
      SEL_CLAIM: rd_data = 32'(claim_id);
      default:   rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (re_i) rdata_o <= rd_data;
      if (we_i) begin
        unique case (sel)
          SEL_PRIO: prio_q[src_sel] <= wdata_i[PRIO_W-1:0];
          SEL_EN:   en_q[ctx_sel][{wrd_sel, 5'b0} +: 32] <=
                      wdata_i & en_mask[{wrd_sel, 5'b0} +: 32];
          SEL_THR:  thr_q[ctx_sel] <= wdata_i[PRIO_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  // R5
  claim_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_hit && claim_id != '0) |=> (rdata_o == 32'($past(claim_id))));

  // R10
  claim_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_hit && claim_id != '0) |=> (best_id[0] != $past(claim_id)));

endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;

  localparam int NS = 31;
  localparam int NC = 2;
  localparam int PW = 3;
  localparam int NW = (NS + 32) / 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [NS-1:0] src = '0;
  logic [NC-1:0] irq;

  irq_ctrl #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW), .ADDR_W(26)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  int m_prio [NS+1];
  bit m_pend [NS+1];
  bit m_svc  [NS+1];
  bit [31:0] m_en [NC];
  int m_thr [NC];
  int exp_rd = 0;
  bit chk_rd = 0;

  function automatic void decode(input int a, output int kind, output int idx, output int c);
    kind = 0; idx = 0; c = 0;
    if (a % 4 != 0) return;
    if (a >= 4 && a <= 4 * NS) begin kind = 1; idx = a / 4; end
    else if (a >= 4096 && a < 4096 + 4 * NW) begin kind = 2; idx = (a - 4096) / 4; end
    else if (a >= 8192 && a < 8192 + 128 * NC && ((a - 8192) % 128) < 4 * NW) begin
      kind = 3; c = (a - 8192) / 128; idx = ((a - 8192) % 128) / 4;
    end else if (a >= 2097152 && a < 2097152 + 4096 * NC) begin
      c = (a - 2097152) / 4096;
      if ((a - 2097152) % 4096 == 0) kind = 4;
      else if ((a - 2097152) % 4096 == 4) kind = 5;
    end
  endfunction

  function automatic int m_best(int c, output int bp);
    int b = 0;
    bp = 0;
    for (int i = 1; i <= NS; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > bp) begin b = i; bp = m_prio[i]; end
    return b;
  endfunction

  function automatic bit [31:0] m_pend_word();
    bit [31:0] w = '0;
    for (int i = 1; i <= NS; i++) w[i] = m_pend[i];
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= NS; i++) begin m_prio[i] = 0; m_pend[i] = 0; m_svc[i] = 0; end
      for (int c = 0; c < NC; c++) begin m_en[c] = '0; m_thr[c] = 0; end
      chk_rd = 0;
    end else begin
      int kind, idx, c, bp, id;
      bit claimed [NS+1];
      bit compl [NS+1];
      for (int i = 0; i <= NS; i++) begin claimed[i] = 0; compl[i] = 0; end
      decode(int'(addr), kind, idx, c);
      if (re) begin
        chk_rd = 1;
        case (kind)
          1: exp_rd = m_prio[idx];
          2: exp_rd = int'(m_pend_word());
          3: exp_rd = int'(m_en[c]);
          4: exp_rd = m_thr[c];
          5: begin id = m_best(c, bp); exp_rd = id; if (id != 0) claimed[id] = 1; end
          default: exp_rd = 0;
        endcase
      end
      if (we) begin
        case (kind)
          1: m_prio[idx] = int'(wdata) % (1 << PW);
          3: begin m_en[c] = wdata; m_en[c][0] = 0; end
          4: m_thr[c] = int'(wdata) % (1 << PW);
          5: if (wdata >= 1 && wdata <= NS && m_en[c][wdata]) compl[wdata] = 1;
          default: ;
        endcase
      end
      for (int i = 1; i <= NS; i++) begin
        if (claimed[i]) begin m_pend[i] = 0; m_svc[i] = 1; end
        else begin
          if (!m_svc[i] && src[i-1]) m_pend[i] = 1;
          if (compl[i]) m_svc[i] = 0;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int bp, e;
      for (int c = 0; c < NC; c++) begin
        void'(m_best(c, bp));
        e = (bp > m_thr[c]) ? 1 : 0;
        check("R6", int'(irq[c]), e);
      end
      if (chk_rd) begin
        check(cur_req, int'(rdata), exp_rd);
        chk_rd = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 26'(a); wdata = 32'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    addr = 26'(a); re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int CLM0 = 32'h200004;
  localparam int CLM1 = 32'h201004;
  localparam int THR0 = 32'h200000;

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1", int'(rdata), 0);
    check("R1", int'(irq), 0);
    cur_req = "R1"; rd(4); rd(32'h1000); rd(32'h2000); rd(THR0); rd(CLM0);

    cur_req = "R2";
    wr(4, 32'hFF); rd(4);
    wr(0, 5); rd(0);
    wr(4 * 31, 2); rd(4 * 31);

    cur_req = "R9";
    wr(32'h1004, 32'hFFFF); rd(32'h1004);
    wr(32'h2100, 32'hFFFF); rd(32'h2100);
    wr(32'h3000, 7); rd(32'h3000);
    wr(6, 3); rd(6); rd(4);
    wr(32'h200008, 3); rd(32'h200008); rd(THR0);

    cur_req = "R3";
    src[2] = 1'b1; idle(2); rd(32'h1000);
    wr(32'h1000, 0); rd(32'h1000);

    cur_req = "R4";
    wr(32'h2000, 32'hFFFF_FFFF); rd(32'h2000);
    wr(32'h2080, 32'h10); rd(32'h2080);

    cur_req = "R5";
    wr(4 * 3, 2); wr(4 * 5, 2); wr(4 * 7, 5);
    src[4] = 1'b1; src[6] = 1'b1; idle(2);
    rd(CLM0); rd(CLM0); rd(CLM0); rd(CLM0);

    cur_req = "R7";
    idle(3); rd(32'h1000); rd(CLM0);

    cur_req = "R8";
    wr(CLM1, 7); idle(2); rd(32'h1000);
    wr(CLM0, 40); wr(CLM0, 0); idle(1); rd(32'h1000);
    wr(CLM0, 7); idle(2); rd(32'h1000);
    wr(CLM0, 3); idle(2); rd(32'h1000);

    cur_req = "R6";
    wr(THR0, 5); idle(2); rd(THR0); rd(CLM0);
    wr(CLM0, 7); idle(2);
    wr(THR0, 4); idle(2);
    wr(THR0, 15); idle(2); rd(THR0);
    wr(THR0, 0);

    cur_req = "R10";
    wr(32'h2080, 32'h18); idle(2);
    rd(CLM0); rd(CLM1); rd(CLM1);
    src = '0;
    wr(CLM0, 3); wr(CLM0, 5); wr(CLM0, 7); idle(2);
    rd(32'h1000); rd(CLM1);

    cur_req = "R5";
    wr(4 * 30, 6); wr(32'h2000, 32'h6000_0000); src[29] = 1'b1; src[30] = 1'b1; idle(2);
    rd(CLM0); rd(CLM0); rd(CLM0);

    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule